// File: doc/BRIEF.md
# Segmented TDMA Bus Arbiter

This block hands a shared bus to one of several processor masters by time alone. A period counter runs from 0 up to a programmed period length and then wraps. Each point in the period belongs to exactly one master. A master gets the grant only while it owns the current slot and is requesting. A slot whose owner is idle stays idle, so the bus timing one master sees never depends on what the others do.

The period is built from up to eight segments. Each segment has a start time, an ordered list of up to four owners and slot lengths. Three schedule styles are available. In the first, every segment is one slot with a single owner. In the second, each owner in a segment's list has its own slot length. In the third, every slot in a segment has the same length. Within a segment the owner list repeats until the next segment starts. A slot cut short by that start is truncated.

A write port fills a shadow copy of the schedule. The shadow copy is copied into the live copy at the start of every period. A write made while the arbiter is disabled restarts the period at once with the new contents.

Top module: `tdma_seg_arbiter`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle. `gnt[m]` is high only when `arb_en` is high, `rst_n` is high, `req[m]` is high and master m owns the current slot.
- R2: When the owner of the current slot has `req` low, no master is granted in that cycle, whatever the other requests are.
- R3: `period_cnt` counts up by one each cycle from 0 to P-1, where P is the programmed period, and then returns to 0. The slot pattern restarts from segment 0, owner position 0 at that point.
- R4: In mode 0 (single slot per segment), segment s runs from its start time to the next active segment's start, or to the end of the period. For that whole time the owner is owner entry 0 of segment s. Segment 0 always begins at count 0, whatever its stored start. Segments whose start is never reached stay unused.
- R5: In mode 1 (per-owner lengths), a segment walks its owner entries 0..K-1 in order. Entry k holds the bus for length entry k. After entry K-1 the walk returns to entry 0, and this repeats until the segment ends. K is the stored owner count plus one.
- R6: In mode 2, and in the spare mode code 3, every slot of a segment lasts length entry 0. Owners are walked as in R5.
- R7: When the next segment's start falls inside a slot, that slot is cut short. The next segment begins exactly at its start count.
- R8: Writes go to a shadow table. The live schedule, including period, mode and segment count, changes only at a period start. A write in the last cycle of a period already counts for the period that follows.
- R9: While `rst_n` is low, `gnt` is all zero. After reset the counter starts at 0 with a default schedule: period 16, one segment, mode 2, owners 0,1,2,3, each slot 4 cycles.
- R10: A write with `cfg_wr` high while `arb_en` is low puts `period_cnt` back to 0 on the next cycle. That period already uses the table with this write applied.
- R11: `cfg_field` selects what a write changes: 0 segment start, 1 owner count minus one, 2 owner id at `cfg_idx`, 3 slot length at `cfg_idx`, 4 period length, 5 segment count minus one, 6 mode (low two bits). Code 7 leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arb_en | input | 1 | Enables grants |
| req | input | 4 | One request per master |
| cfg_wr | input | 1 | Schedule write strobe |
| cfg_field | input | 3 | Field select of the write |
| cfg_seg | input | 3 | Segment index of the write |
| cfg_idx | input | 2 | Owner position of the write |
| cfg_data | input | 16 | Write data |
| gnt | output | 4 | One-hot grant |
| period_cnt | output | 16 | Position in the current period |

## Verification
Two things can land in the same cycle. One is a schedule write. The other is the period wrap that copies the shadow table into the live one. The bench provokes this by rewriting owner ids, slot lengths and mode while the arbiter runs, over many randomly sized periods, so that some writes fall on the wrap cycle. A reference model applies each write before the copy, and every grant in the next period is compared against it.

// File: rtl/tdma_pkg.sv
`timescale 1ns/1ps
// Shared sizes, schedule types and helper functions for the TDMA arbiter.
// Assumes NUM_SEGS and SLOTS_PER_SEG are powers of two.
package tdma_pkg;
    parameter int NUM_MASTERS   = 4;
    parameter int NUM_SEGS      = 8;
    parameter int SLOTS_PER_SEG = 4;
    parameter int TW            = 16;

    localparam int MW = $clog2(NUM_MASTERS);
    localparam int SW = $clog2(NUM_SEGS);
    localparam int OW = $clog2(SLOTS_PER_SEG);

    localparam logic [2:0] FLD_START  = 3'd0;
    localparam logic [2:0] FLD_COUNT  = 3'd1;
    localparam logic [2:0] FLD_OWNER  = 3'd2;
    localparam logic [2:0] FLD_LEN    = 3'd3;
    localparam logic [2:0] FLD_PERIOD = 3'd4;
    localparam logic [2:0] FLD_NSEG   = 3'd5;
    localparam logic [2:0] FLD_MODE   = 3'd6;

    typedef logic [TW-1:0] time_t;

    typedef enum logic [1:0] {
        MODE_SLOT = 2'd0,
        MODE_LEN  = 2'd1,
        MODE_UNI  = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;

    typedef struct packed {
        time_t                                start;
        logic [OW-1:0]                        cnt_m1;
        logic [SLOTS_PER_SEG-1:0][MW-1:0]     owner;
        logic [SLOTS_PER_SEG-1:0][TW-1:0]     len;
    } seg_t;

    typedef struct packed {
        time_t                    period;
        logic [SW-1:0]            nseg_m1;
        mode_e                    mode;
        seg_t [NUM_SEGS-1:0]      seg;
    } sched_t;

    // Schedule loaded at reset: one segment, owners in id order, 4-cycle slots.
    function automatic sched_t default_sched();
        sched_t d;
        d         = '0;
        d.period  = TW'(16);
        d.mode    = MODE_UNI;
        for (int g = 0; g < NUM_SEGS; g++) begin
            d.seg[g].cnt_m1 = OW'(SLOTS_PER_SEG - 1);
            for (int o = 0; o < SLOTS_PER_SEG; o++) begin
                d.seg[g].owner[o] = MW'(o % NUM_MASTERS);
                d.seg[g].len[o]   = TW'(4);
            end
        end
        return d;
    endfunction

    // Length of slot o of segment g; single-slot mode never expires on its own.
    function automatic time_t slot_len(sched_t s, logic [SW-1:0] g, logic [OW-1:0] o);
        case (s.mode)
            MODE_SLOT: return '1;
            MODE_LEN:  return s.seg[g].len[o];
            default:   return s.seg[g].len[0];
        endcase
    endfunction

    // Owner of slot o of segment g under the live mode.
    function automatic logic [MW-1:0] slot_owner(sched_t s, logic [SW-1:0] g, logic [OW-1:0] o);
        if (s.mode == MODE_SLOT) return s.seg[g].owner[0];
        return s.seg[g].owner[o];
    endfunction
endpackage

// File: rtl/tdma_sched_table.sv
`timescale 1ns/1ps
// Shadow and live copies of the schedule. Writes land in the shadow copy;
// on commit the live copy takes the shadow including any same-cycle write.
// Assumes the writer keeps segment starts ascending.
module tdma_sched_table
    import tdma_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_field,
    input  logic [SW-1:0] wr_seg,
    input  logic [OW-1:0] wr_idx,
    input  time_t         wr_data,
    input  logic          commit,
    output sched_t        act,
    output sched_t        nxt
);
    sched_t shadow;

    // Shadow contents after this cycle's write.
    always_comb begin
        nxt = shadow;
        if (wr_en) begin
            case (wr_field)
                FLD_START:  nxt.seg[wr_seg].start          = wr_data;
                FLD_COUNT:  nxt.seg[wr_seg].cnt_m1         = wr_data[OW-1:0];
                FLD_OWNER:  nxt.seg[wr_seg].owner[wr_idx]  = wr_data[MW-1:0];
                FLD_LEN:    nxt.seg[wr_seg].len[wr_idx]    = wr_data;
                FLD_PERIOD: nxt.period                     = wr_data;
                FLD_NSEG:   nxt.nseg_m1                    = wr_data[SW-1:0];
                FLD_MODE:   nxt.mode                       = mode_e'(wr_data[1:0]);
                default:    ;
            endcase
        end
    end

    // Register shadow every cycle; live copy only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= default_sched();
            act    <= default_sched();
        end else begin
            shadow <= nxt;
            if (commit) act <= nxt;
        end
    end

    a_r8_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act));
endmodule

// File: rtl/tdma_slot_seq.sv
`timescale 1ns/1ps
// Period counter plus segment / owner-position tracking. A down-counter holds
// the cycles left in the current slot, so no division is needed. A segment
// start preempts a running slot (truncation). Assumes period >= 1 and slot
// lengths >= 1.
module tdma_slot_seq
    import tdma_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  sched_t        act,
    input  sched_t        nxt,
    output time_t         cnt,
    output logic [SW-1:0] seg,
    output logic [OW-1:0] own,
    output logic          commit
);
    time_t         left;
    time_t         ncnt;
    logic [SW-1:0] seg_up;
    logic [OW-1:0] own_up;
    logic          bound;
    logic          expire;

    // Next-position decode for the current cycle.
    always_comb begin
        ncnt   = cnt + 1'b1;
        seg_up = seg + 1'b1;
        own_up = (own == act.seg[seg].cnt_m1) ? '0 : own + 1'b1;
        bound  = (seg != act.nseg_m1) && (ncnt == act.seg[seg_up].start);
        expire = (left == TW'(1));
        commit = restart || (cnt == act.period - 1'b1);
    end

    // Advance counter, segment and slot position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            seg  <= '0;
            own  <= '0;
            left <= slot_len(default_sched(), '0, '0);
        end else if (commit) begin
            cnt  <= '0;
            seg  <= '0;
            own  <= '0;
            left <= slot_len(nxt, '0, '0);
        end else begin
            cnt <= ncnt;
            if (bound) begin
                seg  <= seg_up;
                own  <= '0;
                left <= slot_len(act, seg_up, '0);
            end else if (expire) begin
                own  <= own_up;
                left <= slot_len(act, seg, own_up);
            end else begin
                left <= left - 1'b1;
            end
        end
    end

    a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> cnt == $past(cnt) + 1'b1);
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (cnt == '0 && seg == '0 && own == '0));
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt == '0);
    a_r7_seg_on_time: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && seg != act.nseg_m1 && ncnt == act.seg[seg_up].start)
        |=> (seg == $past(seg_up) && own == '0));
    a_r5_pos_in_list: assert property (@(posedge clk) disable iff (!rst_n)
        own <= act.seg[seg].cnt_m1);
endmodule

// File: rtl/tdma_grant_gen.sv
`timescale 1ns/1ps
// One-hot grant decode: the slot owner is granted only if it requests and
// the arbiter is enabled and out of reset. Idle slots are never reused.
module tdma_grant_gen #(
    parameter int NM = 4,
    parameter int MW = 2
) (
    input  logic          rst_n,
    input  logic          en,
    input  logic [NM-1:0] req,
    input  logic [MW-1:0] owner,
    output logic [NM-1:0] gnt
);
    for (genvar m = 0; m < NM; m++) begin : g_dec
        assign gnt[m] = rst_n && en && req[m] && (owner == MW'(m));
    end
endmodule

// File: rtl/tdma_seg_arbiter.sv
`timescale 1ns/1ps
// Segmented time-division bus arbiter top. Ties the schedule table, the
// slot sequencer and the grant decoder together. A write while disabled
// restarts the period with the new table.
module tdma_seg_arbiter
    import tdma_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   arb_en,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic                   cfg_wr,
    input  logic [2:0]             cfg_field,
    input  logic [SW-1:0]          cfg_seg,
    input  logic [OW-1:0]          cfg_idx,
    input  logic [TW-1:0]          cfg_data,
    output logic [NUM_MASTERS-1:0] gnt,
    output logic [TW-1:0]          period_cnt
);
    sched_t        act;
    sched_t        nxt;
    logic [SW-1:0] seg;
    logic [OW-1:0] own;
    logic          commit;
    logic          restart;
    logic [MW-1:0] owner;

    // Restart request and current owner lookup.
    always_comb begin
        restart = cfg_wr && !arb_en;
        owner   = slot_owner(act, seg, own);
    end

    tdma_sched_table u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_field(cfg_field),
        .wr_seg(cfg_seg), .wr_idx(cfg_idx), .wr_data(cfg_data),
        .commit(commit), .act(act), .nxt(nxt)
    );

    tdma_slot_seq u_seq (
        .clk(clk), .rst_n(rst_n), .restart(restart), .act(act), .nxt(nxt),
        .cnt(period_cnt), .seg(seg), .own(own), .commit(commit)
    );

    tdma_grant_gen #(.NM(NUM_MASTERS), .MW(MW)) u_gnt (
        .rst_n(rst_n), .en(arb_en), .req(req), .owner(owner), .gnt(gnt)
    );

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    a_r1_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    a_r2_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !req[owner] |-> gnt == '0);
    a_r1_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(seg) && $stable(own) && $stable(req) && $stable(arb_en)
         && period_cnt != '0) |-> $stable(gnt));
endmodule

// File: tb/tdma_seg_arbiter_tb.sv
`timescale 1ns/1ps
module tdma_seg_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, arb_en = 1'b0, cfg_wr = 1'b0;
    logic [3:0]  req = '0;
    logic [2:0]  cfg_field = '0, cfg_seg = '0;
    logic [1:0]  cfg_idx = '0;
    logic [15:0] cfg_data = '0;
    logic [3:0]  gnt;
    logic [15:0] period_cnt;

    always #4 clk = ~clk;

    tdma_seg_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .req(req), .cfg_wr(cfg_wr),
        .cfg_field(cfg_field), .cfg_seg(cfg_seg), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .gnt(gnt), .period_cnt(period_cnt)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Stimulus values applied at the next falling edge.
    logic       g_rst = 0, g_en = 0, g_wr = 0;
    logic [3:0] g_req = 0;
    int         g_fld = 0, g_seg = 0, g_idx = 0, g_dat = 0;

    // Reference model: shadow and live schedule.
    int sh_start[8], sh_cm1[8], sh_own[8][4], sh_len[8][4], sh_per, sh_nsm1, sh_mode;
    int ac_start[8], ac_cm1[8], ac_own[8][4], ac_len[8][4], ac_per, ac_nsm1, ac_mode;
    int m_cnt = 0;

    task automatic model_default();
        sh_per = 16; sh_nsm1 = 0; sh_mode = 2;
        for (int g = 0; g < 8; g++) begin
            sh_start[g] = 0; sh_cm1[g] = 3;
            for (int o = 0; o < 4; o++) begin sh_own[g][o] = o; sh_len[g][o] = 4; end
        end
    endtask

    task automatic model_commit();
        ac_per = sh_per; ac_nsm1 = sh_nsm1; ac_mode = sh_mode;
        for (int g = 0; g < 8; g++) begin
            ac_start[g] = sh_start[g]; ac_cm1[g] = sh_cm1[g];
            for (int o = 0; o < 4; o++) begin
                ac_own[g][o] = sh_own[g][o]; ac_len[g][o] = sh_len[g][o];
            end
        end
    endtask

    task automatic model_write();
        case (g_fld)
            0: sh_start[g_seg] = g_dat & 16'hFFFF;
            1: sh_cm1[g_seg] = g_dat & 3;
            2: sh_own[g_seg][g_idx] = g_dat & 3;
            3: sh_len[g_seg][g_idx] = g_dat & 16'hFFFF;
            4: sh_per = g_dat & 16'hFFFF;
            5: sh_nsm1 = g_dat & 7;
            6: sh_mode = g_dat & 3;
            default: ;
        endcase
    endtask

    // Owner the requirements assign to count t under the live model table.
    function automatic int exp_owner(int t);
        int s = 0, off, k = 0, l;
        for (int i = 1; i <= ac_nsm1; i++) if (ac_start[i] <= t) s = i;
        if (ac_mode == 0) return ac_own[s][0];
        off = t - ((s == 0) ? 0 : ac_start[s]);
        l = (ac_mode == 1) ? ac_len[s][k] : ac_len[s][0];
        while (off >= l) begin
            off -= l;
            k = (k == ac_cm1[s]) ? 0 : k + 1;
            l = (ac_mode == 1) ? ac_len[s][k] : ac_len[s][0];
        end
        return ac_own[s][k];
    endfunction

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // One cycle: drive at falling edge, check, then step the model at the rising edge.
    task automatic cyc(input string tag);
        int eo;
        logic [3:0] eg;
        string t2;
        @(negedge clk);
        rst_n = g_rst; arb_en = g_en; req = g_req; cfg_wr = g_wr;
        cfg_field = 3'(g_fld); cfg_seg = 3'(g_seg); cfg_idx = 2'(g_idx); cfg_data = 16'(g_dat);
        #1;
        eo = exp_owner(m_cnt);
        eg = (g_rst && g_en && g_req[eo]) ? 4'(1 << eo) : 4'd0;
        t2 = tag;
        if (!g_rst) t2 = "R9";
        else if (!g_en) t2 = (tag == "R10") ? tag : "R1";
        else if (!g_req[eo]) t2 = "R2";
        chk(t2, "gnt", int'(gnt), int'(eg));
        chk((m_cnt == 0) ? "R3" : tag, "period_cnt", int'(period_cnt), m_cnt);
        @(posedge clk);
        if (!g_rst) begin
            model_default(); model_commit(); m_cnt = 0;
        end else begin
            if (g_wr) model_write();
            if (g_wr && !g_en) begin model_commit(); m_cnt = 0; end
            else if (m_cnt == ac_per - 1) begin model_commit(); m_cnt = 0; end
            else m_cnt++;
        end
    endtask

    task automatic wr(input int f, input int s, input int i, input int d, input string tag);
        g_wr = 1; g_fld = f; g_seg = s; g_idx = i; g_dat = d;
        cyc(tag);
        g_wr = 0;
    endtask

    task automatic run(input int n, input string tag, input bit rnd);
        for (int i = 0; i < n; i++) begin
            g_req = rnd ? 4'($urandom % 16) : 4'hF;
            g_en  = rnd ? (($urandom % 10) != 0) : 1'b1;
            cyc(tag);
        end
    endtask

    function automatic string mode_tag(int m);
        return (m == 0) ? "R4" : (m == 1) ? "R5" : "R6";
    endfunction

    // Full random schedule, loaded while disabled (R10).
    task automatic prog_random();
        int n, st, per;
        g_en = 0;
        per = 24 + int'($urandom % 40);
        n = 1 + int'($urandom % 4);
        wr(4, 0, 0, per, "R10");
        wr(5, 0, 0, n - 1, "R10");
        wr(6, 0, 0, int'($urandom % 4), "R10");
        st = 0;
        for (int g = 0; g < n; g++) begin
            wr(0, g, 0, st, "R10");
            wr(1, g, 0, int'($urandom % 4), "R10");
            for (int o = 0; o < 4; o++) begin
                wr(2, g, o, int'($urandom % 4), "R10");
                wr(3, g, o, 1 + int'($urandom % 6), "R10");
            end
            st += 3 + int'($urandom % 8);
        end
        chk("R10", "period_cnt after load", m_cnt, 0);
    endtask

    // Owners, lengths and mode rewritten while running (R8).
    task automatic reprog_live();
        g_en = 1;
        wr(6, 0, 0, int'($urandom % 4), "R8");
        for (int g = 0; g <= sh_nsm1; g++)
            for (int o = 0; o < 4; o++) begin
                g_req = 4'($urandom % 16);
                wr(2, g, o, int'($urandom % 4), "R8");
                wr(3, g, o, 1 + int'($urandom % 6), "R8");
            end
    endtask

    initial begin
        void'($urandom(32'd20417));
        model_default(); model_commit();
        repeat (2) @(posedge clk);
        g_rst = 0; g_req = 4'hF; g_en = 1;
        repeat (3) cyc("R9");
        g_rst = 1;
        run(40, "R9", 0);

        // R4: single-slot segments at uneven boundaries.
        g_en = 0;
        wr(4, 0, 0, 60, "R10"); wr(5, 0, 0, 6, "R10"); wr(6, 0, 0, 0, "R10");
        begin
            int b[7] = '{0, 8, 16, 24, 32, 42, 52};
            int ow[7] = '{0, 1, 0, 1, 2, 1, 3};
            for (int g = 0; g < 7; g++) begin
                wr(0, g, 0, b[g], "R4"); wr(2, g, 0, ow[g], "R4");
            end
        end
        run(130, "R4", 0);

        // R7: truncated slot before segment 1 at count 7.
        g_en = 0;
        wr(4, 0, 0, 14, "R10"); wr(5, 0, 0, 1, "R10"); wr(6, 0, 0, 1, "R10");
        wr(1, 0, 0, 1, "R7"); wr(2, 0, 0, 2, "R7"); wr(2, 0, 1, 3, "R7");
        wr(3, 0, 0, 5, "R7"); wr(3, 0, 1, 5, "R7");
        wr(0, 1, 0, 7, "R7"); wr(1, 1, 0, 0, "R7"); wr(2, 1, 0, 1, "R7"); wr(3, 1, 0, 2, "R7");
        run(40, "R7", 0);

        // R11: field code 7 leaves the table untouched.
        g_en = 1;
        wr(7, 0, 0, 16'hFFFF, "R11");
        run(30, "R11", 0);

        // R6 directed: uniform slots of 3.
        g_en = 0;
        wr(6, 0, 0, 2, "R10"); wr(4, 0, 0, 30, "R10"); wr(5, 0, 0, 0, "R10");
        wr(1, 0, 0, 2, "R6"); wr(3, 0, 0, 3, "R6"); wr(3, 0, 1, 9, "R6");
        run(70, "R6", 0);

        for (int it = 0; it < 30; it++) begin
            prog_random();
            run(2 * ac_per + 10, mode_tag(ac_mode), 1);
            if (it % 2 == 1) begin
                reprog_live();
                run(2 * ac_per + 10, "R8", 1);
            end
            if (it == 15) begin
                g_rst = 0; repeat (2) cyc("R9");
                g_rst = 1; run(40, "R9", 1);
            end
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule